// File: doc/BRIEF.md
# Multi-Port GPIO Controller

The block is a memory-mapped general-purpose I/O controller on a simple 32-bit register bus. The bus has a byte address, a write enable and write data. Read data is registered and valid one cycle after the address is presented. It drives pad output-data and output-enable vectors for three bidirectional ports of 8, 24 and 13 pins. It also serves a mixed fourth group. That group holds 6 bidirectional pins, 29 input-only bits and 24 output-only bits, and it drives a pin-select vector used by surrounding multiplexing logic.

Software never writes an output or direction register directly. Each write-one-to-set register raises bits and each write-one-to-clear register lowers them. Separate state registers read the result back. Pad inputs pass through a two-flop synchroniser before any input-state register shows them.

The fourth group shares registers with other functions at fixed, irregular bit positions. Its bidirectional pins occupy bits 25 to 30 for output and direction. They reuse the port 2 direction registers and appear at scattered positions in the input-state word.

Top module: `gpio_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every output-data bit, every output-enable bit, every pin-select bit and rd_data are 0, so all bidirectional pins are inputs.
- R2: A write of 1 to a bit of an output-set register (port 0 at 0x44, port 1 at 0x64, port 2 at 0x20) drives that pad output high on the next clock edge. A write of 1 to the same bit of the output-clear register (0x48, 0x68, 0x24) drives it low. Bits written 0 keep their value, and no output changes without a write.
- R3: A write of 1 to a direction-set bit (port 0 at 0x50, port 1 at 0x70, port 2 at 0x10) sets that pin's output enable. A write of 1 to the direction-clear bit (0x54, 0x74, 0x14) clears it. Bits written 0 are unchanged.
- R4: The output state reads at 0x4C (port 0), 0x6C (port 1) and 0x0C (fourth group). The direction state reads at 0x58, 0x78 and 0x18 (port 2 in bits 0-12). Each shows its register right-aligned, with unused bits 0.
- R5: Input state reads at 0x40 (port 0), 0x60 (port 1), 0x1C (port 2) and 0x00 (fourth group). Each reflects the pad value through two synchronising flops. After a pad changes, reads registered on the first and second following edges still return the old value, and the read registered on the third edge returns the new one.
- R6: Bidirectional pin n (0 to 5) of the fourth group uses bit n+25 of the fourth-group output set (0x04), output clear (0x08) and output state (0x0C). It uses the same bit of the port 2 direction set (0x10), direction clear (0x14) and direction state (0x18).
- R7: In the fourth-group input state (0x00), bidirectional pins 0 to 4 read at bits 10 to 14 and pin 5 reads at bit 24. The input-only pads read at bits 0 to 28 except those six positions, where the input-only pads are ignored.
- R8: The 24 output-only bits of the fourth group occupy bits 0 to 23 of 0x04, 0x08 and 0x0C.
- R9: The pin-select register is set at 0x28 and cleared at 0x2C with the same write-one semantics. Its state reads at 0x30 and drives sel_out.
- R10: Set/clear addresses, unmapped offsets and unaligned offsets read 0. Writes to read-only or unmapped offsets change no output.
- R11: rd_data presents the value of the register addressed at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte offset of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| p0_in | input | P0_W | Port 0 pad inputs |
| p0_out | output | P0_W | Port 0 pad output data |
| p0_oe | output | P0_W | Port 0 pad output enables |
| p1_in | input | P1_W | Port 1 pad inputs |
| p1_out | output | P1_W | Port 1 pad output data |
| p1_oe | output | P1_W | Port 1 pad output enables |
| p2_in | input | P2_W | Port 2 pad inputs |
| p2_out | output | P2_W | Port 2 pad output data |
| p2_oe | output | P2_W | Port 2 pad output enables |
| g3_io_in | input | 6 | Fourth-group bidirectional pad inputs |
| g3_io_out | output | 6 | Fourth-group bidirectional output data |
| g3_io_oe | output | 6 | Fourth-group bidirectional output enables |
| g3_gpi | input | 29 | Fourth-group input-only pads |
| g3_gpo | output | 24 | Fourth-group output-only pads |
| sel_out | output | SEL_W | Pin-select state |

## Verification
The bench aims at the irregular fourth group. A mapping error there would show bidirectional pins at the wrong input bits. It would also let an input-only pad bleed into bits 10 to 14 or 24, or leave port 2 direction writes without effect on bits 25 to 30. Random set/clear traffic against a bench model catches set and clear swapped, or a write that disturbs bits written 0, because an untouched pad output would change. A directed pad change read on three consecutive edges exposes a synchroniser that is too short or too long. Writes to read-only and unmapped offsets check that a loose address decode does not alter any output.

// File: rtl/gpio_ctrl.sv
module gpio_ctrl #(
  parameter int P0_W  = 8,
  parameter int P1_W  = 24,
  parameter int P2_W  = 13,
  parameter int SEL_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [P0_W-1:0]   p0_in,
  output logic [P0_W-1:0]   p0_out,
  output logic [P0_W-1:0]   p0_oe,
  input  logic [P1_W-1:0]   p1_in,
  output logic [P1_W-1:0]   p1_out,
  output logic [P1_W-1:0]   p1_oe,
  input  logic [P2_W-1:0]   p2_in,
  output logic [P2_W-1:0]   p2_out,
  output logic [P2_W-1:0]   p2_oe,
  input  logic [5:0]        g3_io_in,
  output logic [5:0]        g3_io_out,
  output logic [5:0]        g3_io_oe,
  input  logic [28:0]       g3_gpi,
  output logic [23:0]       g3_gpo,
  output logic [SEL_W-1:0]  sel_out
);
  localparam int IO_W  = 6;
  localparam int GPI_W = 29;
  localparam int GPO_W = 24;
  localparam int IO_LO = 25;
  localparam int IN_W  = P0_W + P1_W + P2_W + IO_W + GPI_W;
  localparam int O_P1  = P0_W;
  localparam int O_P2  = P0_W + P1_W;
  localparam int O_IO  = P0_W + P1_W + P2_W;
  localparam int O_GPI = O_IO + IO_W;

  localparam logic [7:0] A_G3_IN  = 8'h00, A_G3_SET = 8'h04, A_G3_CLR = 8'h08, A_G3_ST = 8'h0C;
  localparam logic [7:0] A_P2_DS  = 8'h10, A_P2_DC  = 8'h14, A_P2_DST = 8'h18, A_P2_IN = 8'h1C;
  localparam logic [7:0] A_P2_SET = 8'h20, A_P2_CLR = 8'h24;
  localparam logic [7:0] A_SEL_S  = 8'h28, A_SEL_C  = 8'h2C, A_SEL_ST = 8'h30;
  localparam logic [7:0] A_P0_IN  = 8'h40, A_P0_SET = 8'h44, A_P0_CLR = 8'h48, A_P0_ST = 8'h4C;
  localparam logic [7:0] A_P0_DS  = 8'h50, A_P0_DC  = 8'h54, A_P0_DST = 8'h58;
  localparam logic [7:0] A_P1_IN  = 8'h60, A_P1_SET = 8'h64, A_P1_CLR = 8'h68, A_P1_ST = 8'h6C;
  localparam logic [7:0] A_P1_DS  = 8'h70, A_P1_DC  = 8'h74, A_P1_DST = 8'h78;

  logic [IN_W-1:0] sync_a, sync_b;
  logic [31:0]     rd_next;

  wire [IN_W-1:0]  pads   = {g3_gpi, g3_io_in, p2_in, p1_in, p0_in};
  wire [P0_W-1:0]  p0_s   = sync_b[P0_W-1:0];
  wire [P1_W-1:0]  p1_s   = sync_b[O_P1 +: P1_W];
  wire [P2_W-1:0]  p2_s   = sync_b[O_P2 +: P2_W];
  wire [IO_W-1:0]  io_s   = sync_b[O_IO +: IO_W];
  wire [GPI_W-1:0] gpi_s  = sync_b[O_GPI +: GPI_W];
  wire [IO_W-1:0]  wd_io  = wr_data[IO_LO +: IO_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= pads;
      sync_b <= sync_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_out <= '0; p0_oe <= '0;
      p1_out <= '0; p1_oe <= '0;
      p2_out <= '0; p2_oe <= '0;
      g3_io_out <= '0; g3_io_oe <= '0;
      g3_gpo <= '0; sel_out <= '0;
    end else if (wr_en) begin
      case (addr)
        A_P0_SET: p0_out <= p0_out |  wr_data[P0_W-1:0];
        A_P0_CLR: p0_out <= p0_out & ~wr_data[P0_W-1:0];
        A_P0_DS:  p0_oe  <= p0_oe  |  wr_data[P0_W-1:0];
        A_P0_DC:  p0_oe  <= p0_oe  & ~wr_data[P0_W-1:0];
        A_P1_SET: p1_out <= p1_out |  wr_data[P1_W-1:0];
        A_P1_CLR: p1_out <= p1_out & ~wr_data[P1_W-1:0];
        A_P1_DS:  p1_oe  <= p1_oe  |  wr_data[P1_W-1:0];
        A_P1_DC:  p1_oe  <= p1_oe  & ~wr_data[P1_W-1:0];
        A_P2_SET: p2_out <= p2_out |  wr_data[P2_W-1:0];
        A_P2_CLR: p2_out <= p2_out & ~wr_data[P2_W-1:0];
        A_P2_DS: begin
          p2_oe    <= p2_oe    | wr_data[P2_W-1:0];
          g3_io_oe <= g3_io_oe | wd_io;
        end
        A_P2_DC: begin
          p2_oe    <= p2_oe    & ~wr_data[P2_W-1:0];
          g3_io_oe <= g3_io_oe & ~wd_io;
        end
        A_G3_SET: begin
          g3_gpo    <= g3_gpo    | wr_data[GPO_W-1:0];
          g3_io_out <= g3_io_out | wd_io;
        end
        A_G3_CLR: begin
          g3_gpo    <= g3_gpo    & ~wr_data[GPO_W-1:0];
          g3_io_out <= g3_io_out & ~wd_io;
        end
        A_SEL_S: sel_out <= sel_out |  wr_data[SEL_W-1:0];
        A_SEL_C: sel_out <= sel_out & ~wr_data[SEL_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr)
      A_G3_IN: begin
        rd_next[GPI_W-1:0] = gpi_s;
        rd_next[14:10]     = io_s[4:0];
        rd_next[24]        = io_s[5];
      end
      A_G3_ST: begin
        rd_next[GPO_W-1:0]       = g3_gpo;
        rd_next[IO_LO +: IO_W]   = g3_io_out;
      end
      A_P2_DST: begin
        rd_next[P2_W-1:0]        = p2_oe;
        rd_next[IO_LO +: IO_W]   = g3_io_oe;
      end
      A_P2_IN:  rd_next[P2_W-1:0]  = p2_s;
      A_SEL_ST: rd_next[SEL_W-1:0] = sel_out;
      A_P0_IN:  rd_next[P0_W-1:0]  = p0_s;
      A_P0_ST:  rd_next[P0_W-1:0]  = p0_out;
      A_P0_DST: rd_next[P0_W-1:0]  = p0_oe;
      A_P1_IN:  rd_next[P1_W-1:0]  = p1_s;
      A_P1_ST:  rd_next[P1_W-1:0]  = p1_out;
      A_P1_DST: rd_next[P1_W-1:0]  = p1_oe;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_next;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (p0_oe == '0 && p1_oe == '0 && p2_oe == '0 && g3_io_oe == '0 &&
                p0_out == '0 && g3_gpo == '0 && rd_data == '0));

  a_r2_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_P0_SET) |=>
      ((p0_out & $past(wr_data[P0_W-1:0])) == $past(wr_data[P0_W-1:0])));

  a_r2_clear_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_P1_CLR) |=> ((p1_out & $past(wr_data[P1_W-1:0])) == '0));

  a_r2_zero_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_P0_SET) |=>
      ((p0_out & ~$past(wr_data[P0_W-1:0])) == ($past(p0_out) & ~$past(wr_data[P0_W-1:0]))));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(p0_out) && $stable(p1_out) && $stable(p2_out) &&
                $stable(g3_gpo) && $stable(g3_io_out) && $stable(p2_oe)));

  a_r3_dir_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_P2_DC) |=> ((p2_oe & $past(wr_data[P2_W-1:0])) == '0));

  a_r6_shared_dir_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_P2_DS) |=> ((g3_io_oe & $past(wd_io)) == $past(wd_io)));

  a_r10_readonly_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_G3_ST || addr == A_P0_IN)) |=>
      ($stable(g3_gpo) && $stable(g3_io_out) && $stable(p0_out) && $stable(p0_oe)));
endmodule

// File: tb/gpio_ctrl_tb.sv
module gpio_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [7:0]  p0_in = '0, p0_out, p0_oe;
  logic [23:0] p1_in = '0, p1_out, p1_oe;
  logic [12:0] p2_in = '0, p2_out, p2_oe;
  logic [5:0]  g3_io_in = '0, g3_io_out, g3_io_oe;
  logic [28:0] g3_gpi = '0;
  logic [23:0] g3_gpo;
  logic [31:0] sel_out;

  int checks = 0, errors = 0;

  logic [7:0]  m_p0o = '0, m_p0d = '0;
  logic [23:0] m_p1o = '0, m_p1d = '0, m_gpo = '0;
  logic [12:0] m_p2o = '0, m_p2d = '0;
  logic [5:0]  m_io = '0, m_iod = '0;
  logic [31:0] m_sel = '0;

  gpio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data),
    .p0_in(p0_in), .p0_out(p0_out), .p0_oe(p0_oe),
    .p1_in(p1_in), .p1_out(p1_out), .p1_oe(p1_oe),
    .p2_in(p2_in), .p2_out(p2_out), .p2_oe(p2_oe),
    .g3_io_in(g3_io_in), .g3_io_out(g3_io_out), .g3_io_oe(g3_io_oe),
    .g3_gpi(g3_gpi), .g3_gpo(g3_gpo), .sel_out(sel_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] g3_in_word(input logic [28:0] gpi, input logic [5:0] io);
    logic [31:0] v = {3'b0, gpi};
    v[14:10] = io[4:0];
    v[24]    = io[5];
    return v;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    logic [31:0] v = '0;
    case (a)
      8'h00: v = g3_in_word(g3_gpi, g3_io_in);
      8'h0C: begin v[23:0] = m_gpo; v[30:25] = m_io; end
      8'h18: begin v[12:0] = m_p2d; v[30:25] = m_iod; end
      8'h1C: v[12:0] = p2_in;
      8'h30: v = m_sel;
      8'h40: v[7:0] = p0_in;
      8'h4C: v[7:0] = m_p0o;
      8'h58: v[7:0] = m_p0d;
      8'h60: v[23:0] = p1_in;
      8'h6C: v[23:0] = m_p1o;
      8'h78: v[23:0] = m_p1d;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h04: begin m_gpo |= d[23:0];  m_io |= d[30:25];  end
      8'h08: begin m_gpo &= ~d[23:0]; m_io &= ~d[30:25]; end
      8'h10: begin m_p2d |= d[12:0];  m_iod |= d[30:25]; end
      8'h14: begin m_p2d &= ~d[12:0]; m_iod &= ~d[30:25]; end
      8'h20: m_p2o |= d[12:0];
      8'h24: m_p2o &= ~d[12:0];
      8'h28: m_sel |= d;
      8'h2C: m_sel &= ~d;
      8'h44: m_p0o |= d[7:0];
      8'h48: m_p0o &= ~d[7:0];
      8'h50: m_p0d |= d[7:0];
      8'h54: m_p0d &= ~d[7:0];
      8'h64: m_p1o |= d[23:0];
      8'h68: m_p1o &= ~d[23:0];
      8'h70: m_p1d |= d[23:0];
      8'h74: m_p1d &= ~d[23:0];
      default: ;
    endcase
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic check_pads(input string req);
    check({req, " p0_out"}, 32'(p0_out), 32'(m_p0o));
    check({req, " p0_oe"},  32'(p0_oe),  32'(m_p0d));
    check({req, " p1_out"}, 32'(p1_out), 32'(m_p1o));
    check({req, " p1_oe"},  32'(p1_oe),  32'(m_p1d));
    check({req, " p2_out"}, 32'(p2_out), 32'(m_p2o));
    check({req, " p2_oe"},  32'(p2_oe),  32'(m_p2d));
    check({req, " g3_io_out"}, 32'(g3_io_out), 32'(m_io));
    check({req, " g3_io_oe"},  32'(g3_io_oe),  32'(m_iod));
    check({req, " g3_gpo"}, 32'(g3_gpo), 32'(m_gpo));
    check({req, " sel_out"}, sel_out, m_sel);
  endtask

  task automatic check_all_reads(input string req);
    logic [31:0] v;
    for (int i = 0; i < 32; i++) begin
      rd(8'(i * 4), v);
      check(req, v, exp_rd(8'(i * 4)));
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 rd_data in reset", rd_data, 32'h0);
    check_pads("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_pads("R1 after reset");
    check_all_reads("R1 reads after reset");

    wr(8'h44, 32'h0000_0005);
    check("R2 p0 set bits 0,2", 32'(p0_out), 32'h05);
    wr(8'h44, 32'h0000_0080);
    check("R2 p0 zero bits hold", 32'(p0_out), 32'h85);
    wr(8'h48, 32'h0000_0004);
    check("R2 p0 clear bit 2", 32'(p0_out), 32'h81);
    wr(8'h20, 32'h0000_1001);
    check("R2 p2 set", 32'(p2_out), 32'h1001);
    wr(8'h70, 32'h0080_0001);
    check("R3 p1 dir set", 32'(p1_oe), 32'h80_0001);
    wr(8'h74, 32'h0000_0001);
    check("R3 p1 dir clear", 32'(p1_oe), 32'h80_0000);
    rd(8'h78, v);
    check("R4 p1 dir state", v, 32'h0080_0000);

    wr(8'h10, 32'h4200_0003);
    check("R6 g3 dir via port2 set", 32'(g3_io_oe), 32'h21);
    check("R3 p2 dir set", 32'(p2_oe), 32'h3);
    wr(8'h04, 32'h0400_0001);
    check("R6 g3 bidir out bit 26", 32'(g3_io_out), 32'h02);
    check("R8 g3 gpo bit 0", 32'(g3_gpo), 32'h1);
    rd(8'h0C, v);
    check("R6 g3 output state", v, 32'h0400_0001);
    wr(8'h14, 32'h4000_0000);
    check("R6 g3 dir clear bit 30", 32'(g3_io_oe), 32'h01);
    rd(8'h18, v);
    check("R4 p2 dir state", v, 32'h0200_0003);

    wr(8'h28, 32'hF000_000F);
    wr(8'h2C, 32'h1000_0001);
    check("R9 select state", sel_out, 32'hE000_000E);

    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h7C, 32'hFFFF_FFFF);
    check_pads("R10 read-only writes");
    rd(8'h44, v);
    check("R10 set address reads 0", v, 32'h0);
    rd(8'h4D, v);
    check("R10 unaligned reads 0", v, 32'h0);

    g3_gpi = 29'h1FFF_FFFF; g3_io_in = 6'h00;
    settle();
    rd(8'h00, v);
    check("R7 gpi ignored at shared bits", v, 32'h1EFF_83FF);
    g3_gpi = '0; g3_io_in = 6'h3F;
    settle();
    rd(8'h00, v);
    check("R7 bidir input positions", v, 32'h0100_7C00);

    @(negedge clk);
    p0_in = 8'hA5; addr = 8'h40;
    @(negedge clk);
    check("R5 first edge still old", rd_data, 32'h0);
    @(negedge clk);
    check("R5 second edge still old", rd_data, 32'h0);
    @(negedge clk);
    check("R5 third edge shows new", rd_data, 32'hA5);
    check("R11 registered read", rd_data, exp_rd(8'h40));

    for (int it = 0; it < 400; it++) begin
      logic [7:0]  a = 8'($urandom_range(0, 31) * 4);
      logic [31:0] d = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : $urandom;
      wr(a, d);
      check_pads("R2 R3 R6 R8 R9 random");
      if (it % 20 == 0) begin
        p0_in = 8'($urandom); p1_in = 24'($urandom); p2_in = 13'($urandom);
        g3_io_in = 6'($urandom); g3_gpi = 29'($urandom);
        settle();
        check_all_reads("R4 R5 R7 random reads");
      end
    end

    summary();
    $finish;
  end
endmodule